// File: doc/BRIEF.md
# Serial DAC Sawtooth Streamer

This block feeds an external 12-bit serial DAC with an endless staircase ramp. A fixed queue of sixteen 16-bit command words is sent to the converter one after another. Each word carries a 4-bit control code in its upper nibble and a 12-bit output level in its lower bits. After the last entry the queue pointer returns to entry zero without pausing, so the converter output is a repeating sixteen-step sawtooth.

Each word is framed by its own active-low chip-select pulse. A programmable lead delay separates chip-select assertion from the first clock, and a programmable gap follows each word. The serial clock idles low. Data is shifted on the falling edge so that it is settled when the converter samples it on the rising edge.

The serial bit rate sets the ramp frequency. A push button re-derives the bit rate from a 12-bit potentiometer sample. On each press, the clock divisor is rescaled linearly onto the range 2 to 255 system clocks per half period. A new divisor takes effect only at the next word boundary.

Top module: `sdac_streamer`

## Requirements
- R1: While reset is held and immediately after it, cs_n is high and sclk is low. The divisor starts at 2, so the first words after reset have sclk high and low phases of 2 clock cycles each.
- R2: Queue entry i (i = 0..15) is the word 0x7000 + i*0x111. Bits 15:12 hold the control code 0x7 and bits 11:0 hold the level. Each word is sent most significant bit first.
- R3: Words are sent in ascending entry order. The word after entry 15 is entry 0, and the sequence never halts.
- R4: sclk is low whenever cs_n is high. Each cs_n low pulse contains exactly 16 sclk rising edges, and cs_n rises on the same clock edge on which sclk falls after the 16th high phase.
- R5: While cs_n is low, mosi changes only on the clock edge where sclk falls, so it is stable across every sclk rising edge.
- R6: Every sclk high phase, and every low phase between two bits of a word, lasts exactly the active divisor in system clock cycles. The sclk frequency is therefore fclk/(2*divisor).
- R7: A button press loads the divisor 2 + (253*sample)/4095, using integer division, where sample is the 12-bit potentiometer value. Sample 0 gives 2, 2048 gives 128 and 4095 gives 255.
- R8: A new divisor is first used by the word that starts after the next word boundary. A word already in progress completes at the old rate.
- R9: The button passes through a two-stage synchroniser and acts only on its rising edge. Holding it high causes a single update, and later changes of the sample while it is held have no effect.
- R10: cs_n stays low for 4 cycles plus one divisor before the first sclk rise. cs_n stays high for 4 cycles between consecutive words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pot_sample | input | 12 | Potentiometer conversion result, unsigned |
| button | input | 1 | Asynchronous push-button level, active high |
| sclk | output | 1 | Serial clock to the DAC, idles low |
| mosi | output | 1 | Serial data to the DAC |
| cs_n | output | 1 | Active-low chip select, one pulse per word |

## Verification
The assertions assume that the potentiometer sample is steady during the few cycles between a button rising edge and its detection after the synchroniser. They also assume that each press stays high and then low for longer than the synchroniser depth, so that one level change cannot be seen twice. The stimulus sets the sample before raising the button, holds every press and release for several cycles, and changes the sample only well after a press has been taken, or while the button is deliberately held. Random samples are drawn from a fixed seed and limited to the lower quarter of the range to bound run time. The extremes 0 and 4095 and the midpoint are applied as directed cases.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   typedef enum logic [1:0] {
      SD_GAP  = 2'd0,
      SD_LEAD = 2'd1,
      SD_LOW  = 2'd2,
      SD_HIGH = 2'd3
   } sdac_state_e;

   function automatic int unsigned sdac_max3(input int unsigned a, input int unsigned b,
                                             input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/sdac_btn_sync.sv
module sdac_btn_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_i,
   output logic press_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdac_btn_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], btn_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign press_o = sync_q[STAGES-1] & ~prev_q;

   // R9: a held level yields exactly one press pulse
   a_r9_single_press: assert property (@(posedge clk) disable iff (!rst_n)
      press_o |=> !press_o);
endmodule

// File: rtl/sdac_rate.sv
module sdac_rate #(
   parameter int SAMPLE_W = 12,
   parameter int DIV_MIN  = 2,
   parameter int DIV_MAX  = 255,
   parameter int DIV_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                press_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   input  logic                word_done_i,
   output logic [DIV_W-1:0]    div_o
);
   localparam int SPAN   = (1 << SAMPLE_W) - 1;
   localparam int RANGE  = DIV_MAX - DIV_MIN;
   localparam int PROD_W = SAMPLE_W + $clog2(RANGE + 1);

   generate
      if (DIV_MIN < 1 || DIV_MAX <= DIV_MIN || DIV_MAX >= (1 << DIV_W)) begin : g_bad_div
         $error("sdac_rate: divisor limits do not fit");
      end
   endgenerate

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] quot;
   logic [DIV_W-1:0]  div_cand;
   logic [DIV_W-1:0]  div_pend_q;
   logic [DIV_W-1:0]  div_act_q;

   assign prod     = PROD_W'(sample_i) * PROD_W'(RANGE);
   assign quot     = prod / PROD_W'(SPAN);
   assign div_cand = DIV_W'(DIV_MIN) + quot[DIV_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_pend_q <= DIV_W'(DIV_MIN);
         div_act_q  <= DIV_W'(DIV_MIN);
      end else begin
         if (press_i)
            div_pend_q <= div_cand;
         if (word_done_i)
            div_act_q <= press_i ? div_cand : div_pend_q;
      end
   end

   assign div_o = div_act_q;

   // R7: the applied divisor stays inside its legal range
   a_r7_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (div_act_q >= DIV_W'(DIV_MIN)) && (div_act_q <= DIV_W'(DIV_MAX)));
   // R8: the rate only moves at a word boundary
   a_r8_div_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !word_done_i |=> $stable(div_act_q));
endmodule

// File: rtl/sdac_engine.sv
module sdac_engine
   import sdac_pkg::*;
#(
   parameter int                      WORD_W    = 16,
   parameter int                      LEVEL_W   = 12,
   parameter int                      DEPTH     = 16,
   parameter logic [WORD_W-LEVEL_W-1:0] CTRL_CODE = 4'h7,
   parameter int                      DIV_W     = 8,
   parameter int                      DIV_MAX   = 255,
   parameter int                      LEAD_DLY  = 4,
   parameter int                      TRAIL_DLY = 4,
   parameter bit                      MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   output logic             sclk_o,
   output logic             mosi_o,
   output logic             cs_n_o,
   output logic             word_done_o
);
   localparam int PTR_W  = $clog2(DEPTH);
   localparam int BIT_W  = $clog2(WORD_W);
   localparam int STEP   = ((1 << LEVEL_W) - 1) / (DEPTH - 1);
   localparam int CNT_W  = $clog2(sdac_max3(DIV_MAX, LEAD_DLY, TRAIL_DLY) + 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2 || LEVEL_W >= WORD_W || LEAD_DLY < 1 || TRAIL_DLY < 1) begin : g_bad_cfg
         $error("sdac_engine: illegal queue or delay configuration");
      end
   endgenerate

   // Preloaded ramp queue: entry g = {control code, g*STEP}
   logic [WORD_W-1:0] queue [DEPTH];
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_queue
         assign queue[g] = {CTRL_CODE, LEVEL_W'(g * STEP)};
      end
   endgenerate

   sdac_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BIT_W-1:0]  bit_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [WORD_W-1:0] shreg_q;
   logic [WORD_W-1:0] sh_next;
   logic              sclk_q;
   logic              cs_n_q;
   logic              cnt_zero;
   logic [CNT_W-1:0]  div_reload;

   generate
      if (MSB_FIRST) begin : g_msb
         assign mosi_o  = shreg_q[WORD_W-1];
         assign sh_next = {shreg_q[WORD_W-2:0], 1'b0};
      end else begin : g_lsb
         assign mosi_o  = shreg_q[0];
         assign sh_next = {1'b0, shreg_q[WORD_W-1:1]};
      end
   endgenerate

   assign cnt_zero    = (cnt_q == '0);
   assign div_reload  = CNT_W'(div_i) - CNT_W'(1);
   assign word_done_o = (state_q == SD_HIGH) && cnt_zero && (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SD_GAP;
         cnt_q   <= CNT_W'(TRAIL_DLY - 1);
         bit_q   <= '0;
         ptr_q   <= '0;
         shreg_q <= '0;
         sclk_q  <= 1'b0;
         cs_n_q  <= 1'b1;
      end else begin
         if (!cnt_zero)
            cnt_q <= cnt_q - CNT_W'(1);
         unique case (state_q)
            SD_GAP: if (cnt_zero) begin
               state_q <= SD_LEAD;
               cnt_q   <= CNT_W'(LEAD_DLY - 1);
               cs_n_q  <= 1'b0;
               shreg_q <= queue[ptr_q];
            end
            SD_LEAD: if (cnt_zero) begin
               state_q <= SD_LOW;
               cnt_q   <= div_reload;
            end
            SD_LOW: if (cnt_zero) begin
               state_q <= SD_HIGH;
               cnt_q   <= div_reload;
               sclk_q  <= 1'b1;
            end
            SD_HIGH: if (cnt_zero) begin
               sclk_q <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  state_q <= SD_GAP;
                  cnt_q   <= CNT_W'(TRAIL_DLY - 1);
                  cs_n_q  <= 1'b1;
                  bit_q   <= '0;
                  ptr_q   <= (ptr_q == LAST_PTR) ? '0 : ptr_q + PTR_W'(1);
               end else begin
                  state_q <= SD_LOW;
                  cnt_q   <= div_reload;
                  bit_q   <= bit_q + BIT_W'(1);
                  shreg_q <= sh_next;
               end
            end
            default: state_q <= SD_GAP;
         endcase
      end
   end

   assign sclk_o = sclk_q;
   assign cs_n_o = cs_n_q;

   // R3: pointer returns to entry zero after the last entry
   a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done_o && ptr_q == LAST_PTR) |=> (ptr_q == '0));
   // R4: the serial clock rests low outside a frame
   a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sclk_q);
   // R4: a frame closes on the falling edge of its final high phase
   a_r4_close_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_q) |-> (!sclk_q && $past(sclk_q)));
   // R5: data only moves on a falling serial clock inside a frame
   a_r5_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_q && $past(!cs_n_q) && !$fell(sclk_q)) |-> $stable(mosi_o));
endmodule

// File: rtl/sdac_streamer.sv
module sdac_streamer #(
   parameter int SAMPLE_W   = 12,
   parameter int WORD_W     = 16,
   parameter int LEVEL_W    = 12,
   parameter int DEPTH      = 16,
   parameter int DIV_MIN    = 2,
   parameter int DIV_MAX    = 255,
   parameter int LEAD_DLY   = 4,
   parameter int TRAIL_DLY  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] pot_sample,
   input  logic                button,
   output logic                sclk,
   output logic                mosi,
   output logic                cs_n
);
   localparam int DIV_W = $clog2(DIV_MAX + 1);

   logic             press;
   logic             word_done;
   logic [DIV_W-1:0] div_act;

   sdac_btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_i   (button),
      .press_o (press)
   );

   sdac_rate #(
      .SAMPLE_W (SAMPLE_W),
      .DIV_MIN  (DIV_MIN),
      .DIV_MAX  (DIV_MAX),
      .DIV_W    (DIV_W)
   ) u_rate (
      .clk         (clk),
      .rst_n       (rst_n),
      .press_i     (press),
      .sample_i    (pot_sample),
      .word_done_i (word_done),
      .div_o       (div_act)
   );

   sdac_engine #(
      .WORD_W    (WORD_W),
      .LEVEL_W   (LEVEL_W),
      .DEPTH     (DEPTH),
      .CTRL_CODE ((WORD_W-LEVEL_W)'(7)),
      .DIV_W     (DIV_W),
      .DIV_MAX   (DIV_MAX),
      .LEAD_DLY  (LEAD_DLY),
      .TRAIL_DLY (TRAIL_DLY),
      .MSB_FIRST (1'b1)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .div_i       (div_act),
      .sclk_o      (sclk),
      .mosi_o      (mosi),
      .cs_n_o      (cs_n),
      .word_done_o (word_done)
   );
endmodule

// File: tb/sdac_streamer_bench.sv
`timescale 1ns/1ps
module sdac_streamer_bench;
   localparam int LEAD  = 4;
   localparam int TRAIL = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] pot_sample = '0;
   logic        button = 1'b0;
   logic        sclk, mosi, cs_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   logic [15:0] m_word;
   int m_gap, m_lead, m_hmin, m_hmax, m_lmin, m_lmax;

   always #4 clk = ~clk;

   sdac_streamer u_sdac_streamer (
      .clk(clk), .rst_n(rst_n), .pot_sample(pot_sample), .button(button),
      .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
   );

   function automatic int exp_div(input int s);
      return 2 + (253 * s) / 4095;
   endfunction

   function automatic logic [15:0] exp_word(input int idx);
      return 16'(16'h7000 + (idx % 16) * 16'h111);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic sync_gap();
      while (cs_n !== 1'b0) @(negedge clk);
      while (cs_n !== 1'b1) @(negedge clk);
   endtask

   // Called at the first negedge of a gap; returns at the first negedge of the next gap.
   task automatic measure_word();
      int h, l;
      m_gap = 0;
      while (cs_n === 1'b1) begin m_gap++; @(negedge clk); end
      m_lead = 0;
      while (sclk === 1'b0 && cs_n === 1'b0) begin m_lead++; @(negedge clk); end
      m_hmin = 99999; m_hmax = 0; m_lmin = 99999; m_lmax = 0; m_word = '0;
      for (int b = 0; b < 16; b++) begin
         m_word = {m_word[14:0], mosi};
         h = 0;
         while (sclk === 1'b1) begin h++; @(negedge clk); end
         if (h < m_hmin) m_hmin = h;
         if (h > m_hmax) m_hmax = h;
         if (b < 15) begin
            l = 0;
            while (sclk === 1'b0 && cs_n === 1'b0) begin l++; @(negedge clk); end
            if (l < m_lmin) m_lmin = l;
            if (l > m_lmax) m_lmax = l;
         end
      end
   endtask

   task automatic check_timing(input int d, input string req);
      chk(m_hmin == d && m_hmax == d, req, m_hmax, d);
      chk(m_lmin == d && m_lmax == d, req, m_lmax, d);
   endtask

   task automatic press(input int s);
      @(negedge clk);
      pot_sample = 12'(s);
      repeat (2) @(negedge clk);
      button = 1'b1;
      repeat (6) @(negedge clk);
      button = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // Two consecutive words after a boundary, checked for rate and ramp order.
   task automatic check_rate(input int s, input string req);
      logic [15:0] w1;
      int idx;
      int d;
      d = exp_div(s);
      press(s);
      sync_gap();
      measure_word();
      w1 = m_word;
      check_timing(d, req);
      chk(m_lead == LEAD + d, "R10 lead", m_lead, LEAD + d);
      chk(w1[15:12] == 4'h7 && (w1[11:0] % 273) == 0, "R2 valid word", w1, 16'h7000);
      idx = w1[11:0] / 273;
      measure_word();
      chk(m_gap == TRAIL, "R10 gap", m_gap, TRAIL);
      chk(m_word == exp_word(idx + 1), "R3 order", m_word, exp_word(idx + 1));
      check_timing(d, req);
   endtask

   initial begin
      int seed_dummy;
      int s;
      seed_dummy = $urandom(32'd355);
      repeat (5) @(negedge clk);
      // R1: idle outputs under reset
      chk(cs_n === 1'b1, "R1 cs_n in reset", cs_n, 1);
      chk(sclk === 1'b0, "R1 sclk in reset", sclk, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n === 1'b1 && sclk === 1'b0, "R1 after reset", {cs_n, sclk}, 2);

      // R1/R2/R3/R4/R6/R10: reset rate, ramp content, wrap
      sync_gap();
      for (int k = 1; k <= 20; k++) begin
         measure_word();
         chk(m_word == exp_word(k), "R2 R3 word", m_word, exp_word(k));
         check_timing(2, "R1 R6 reset divisor");
         chk(m_lead == LEAD + 2, "R10 lead", m_lead, LEAD + 2);
         chk(m_gap == TRAIL, "R4 R10 gap", m_gap, TRAIL);
      end

      // R7: directed corners
      check_rate(0, "R7 sample 0");
      check_rate(2048, "R7 sample 2048");
      check_rate(4095, "R7 sample 4095");

      // R7/R6: random samples
      for (int k = 0; k < 8; k++) begin
         s = int'($urandom % 1024);
         check_rate(s, "R7 random");
      end

      // R8: word in progress keeps old divisor
      check_rate(620, "R8 setup");  // divisor 40
      fork
         measure_word();
         begin
            repeat (200) @(negedge clk);
            press(145);              // divisor 10
         end
      join
      check_timing(exp_div(620), "R8 old rate kept");
      measure_word();
      check_timing(exp_div(145), "R8 new rate at boundary");

      // R9: holding the button gives one update only
      @(negedge clk);
      pot_sample = 12'd300;
      repeat (2) @(negedge clk);
      button = 1'b1;
      repeat (10) @(negedge clk);
      pot_sample = 12'd900;
      sync_gap();
      sync_gap();
      measure_word();
      check_timing(exp_div(300), "R9 held button");
      button = 1'b0;
      repeat (4) @(negedge clk);
      sync_gap();
      measure_word();
      check_timing(exp_div(300), "R9 release no update");

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule